// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block owns the descriptor table of a packet DMA engine and walks the transmit and receive rings through it. The table is a register-mapped array that a host reads and writes over a simple word bus. A single programmable boundary splits the array into two rings. Transmit descriptors run from index 0 up to the boundary, and receive descriptors fill the rest of the array.

A frame transmitter sees the descriptor at the transmit pointer as a request whenever its ready flag is set. The request carries the buffer address, the length and the pad and CRC options. A frame receiver sees the buffer address of the descriptor at the receive pointer whenever its empty flag is set. When an engine pulses its done strobe, the block writes completion status into that descriptor's control word and hands ownership back to the host by clearing the ownership flag. The pointer then advances.

Completions whose descriptor asks for an interrupt set bits in a write-one-to-clear source register. A frame that arrives with no empty receive descriptor also sets a source bit. A mask register gates the interrupt line.

Top module: `desc_ring_seq`

## Requirements
- R1: After a synchronous active-low reset, the outputs and registers are cleared. `tx_valid`, `rx_valid` and `irq` are 0, the descriptor count is 0, and the source, mask and table words all read 0.
- R2: The host bus maps the table at byte offset 0x400, 8 bytes per descriptor, with the control word at +0 and the buffer address at +4. The source register is at 0x04, the mask at 0x08 and the transmit descriptor count at 0x20. A write takes effect at the clock edge and `host_rdata` shows the addressed word combinationally.
- R3: A write to 0x20 stores the count clamped to NUM_DESC. It also restarts the transmit pointer at index 0 and the receive pointer at index count.
- R4: `tx_valid` is 1 when the count is nonzero and bit 15 (ready) of the control word at the transmit pointer is 1. While it is 1, `tx_len` = bits 31:16, `tx_pad` = bit 12, `tx_crc` = bit 11, and `tx_addr` = the buffer word.
- R5: `tx_done` while `tx_valid` rewrites the control word as follows:
  - bits 8:0 become `tx_status` (bit 0 carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun);
  - bit 15 is cleared;
  - all other bits are kept.
  
  The transmit pointer then advances. This engine write-back takes precedence over a host write to the same word in the same cycle.
- R6: `rx_valid` is 1 when the count is below NUM_DESC and bit 15 (empty) of the control word at the receive pointer is 1. While it is 1, `rx_addr` = the buffer word.
- R7: `rx_done` while `rx_valid` rewrites the control word as follows:
  - bits 31:16 become `rx_len`;
  - bits 8:0 become `rx_status`;
  - bit 15 is cleared;
  - bits 14:9 are kept.
  
  The receive pointer then advances.
- R8: A completed descriptor with bit 13 (wrap) set, or one that is the last of its ring, sends the pointer back to the ring's first index: 0 for transmit, count for receive.
- R9: A pointer does not move while its valid output is 0. A `tx_done` in that state changes nothing.
- R10: A completion whose descriptor has bit 14 set raises one source bit. Transmit raises bit 0, or bit 1 if any of status bits 0-3 or 8 are set. Receive raises bit 2, or bit 3 if any of status bits 0-7 are set. A completion with bit 14 clear raises no source bit.
- R11: `rx_done` while `rx_valid` is 0 sets source bit 4 and leaves the table and pointers unchanged.
- R12: Writing 1s to 0x04 clears those source bits, but a bit set by an event in the same cycle stays set. `irq` is 1 exactly when a source bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr |
| tx_valid | output | 1 | Ready transmit descriptor presented |
| tx_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit frame length |
| tx_pad | output | 1 | Pad option of the descriptor |
| tx_crc | output | 1 | CRC option of the descriptor |
| tx_done | input | 1 | Transmit frame finished |
| tx_status | input | 9 | Transmit completion status |
| rx_valid | output | 1 | Empty receive descriptor presented |
| rx_addr | output | 32 | Receive buffer address |
| rx_done | input | 1 | Receive frame finished (or arrived, if none empty) |
| rx_len | input | 16 | Received length including CRC |
| rx_status | input | 9 | Receive completion status |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with NUM_DESC = 8, a 12-bit address and the table at 0x400. This keeps the whole table at 16 words, so both rings reach their wrap flags and their region ends within a handful of completions. A count write of 200 exercises the clamp, and count values of 3, 6 and 8 move the boundary. The count of 8 empties the receive ring entirely, which makes the busy event reachable. A same-cycle host write and engine write-back is driven once, as is a same-cycle clear and set of a source bit.

// File: rtl/desc_ring_pkg.sv
// Package: shared field positions, register offsets and error masks for
// the descriptor ring sequencer. Assumes 32-bit control words.
package desc_ring_pkg;
    localparam int LEN_LSB   = 16;
    localparam int BIT_OWN   = 15;   // ready (transmit) / empty (receive)
    localparam int BIT_IRQ   = 14;
    localparam int BIT_WRAP  = 13;
    localparam int BIT_PAD   = 12;
    localparam int BIT_CRC   = 11;
    localparam int STAT_W    = 9;
    localparam int SRC_W     = 5;

    // source register bit positions
    localparam int SRC_TX_OK  = 0;
    localparam int SRC_TX_ERR = 1;
    localparam int SRC_RX_OK  = 2;
    localparam int SRC_RX_ERR = 3;
    localparam int SRC_BUSY   = 4;

    // status bits that count as errors
    localparam logic [STAT_W-1:0] TX_ERR_MASK = 9'h10F;
    localparam logic [STAT_W-1:0] RX_ERR_MASK = 9'h0FF;

    // control-word bits kept across write-back
    localparam logic [31:0] TX_KEEP = 32'hFFFF_7E00;
    localparam logic [31:0] RX_KEEP = 32'h0000_7E00;

    // register byte offsets
    localparam int OFS_SRC   = 'h04;
    localparam int OFS_MASK  = 'h08;
    localparam int OFS_COUNT = 'h20;
endpackage

// File: rtl/desc_ring_table.sv
// Descriptor storage: two words per descriptor (control, buffer address).
// One host write port, two engine write-back ports that target control
// words only, and three combinational read ports. Engine writes take
// precedence over a host write to the same word. Assumes the transmit and
// receive indices never coincide while both write back.
module desc_ring_table #(
    parameter int NUM_DESC = 128,
    localparam int IDX_W   = $clog2(NUM_DESC),
    localparam int WIDX_W  = IDX_W + 1,
    localparam int WORDS   = 2 * NUM_DESC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WIDX_W-1:0] host_widx,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_word,
    input  logic              tx_wb,
    input  logic [IDX_W-1:0]  tx_idx,
    input  logic [31:0]       tx_wb_word,
    output logic [31:0]       tx_ctl,
    output logic [31:0]       tx_buf,
    input  logic              rx_wb,
    input  logic [IDX_W-1:0]  rx_idx,
    input  logic [31:0]       rx_wb_word,
    output logic [31:0]       rx_ctl,
    output logic [31:0]       rx_buf
);
    logic [31:0] mem_q [WORDS];

    // Table update: host first, later engine assignments override it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else begin
            if (host_we) mem_q[host_widx] <= host_wdata;
            if (tx_wb)   mem_q[{tx_idx, 1'b0}] <= tx_wb_word;
            if (rx_wb)   mem_q[{rx_idx, 1'b0}] <= rx_wb_word;
        end
    end

    assign host_word = mem_q[host_widx];
    assign tx_ctl    = mem_q[{tx_idx, 1'b0}];
    assign tx_buf    = mem_q[{tx_idx, 1'b1}];
    assign rx_ctl    = mem_q[{rx_idx, 1'b0}];
    assign rx_buf    = mem_q[{rx_idx, 1'b1}];
endmodule

// File: rtl/desc_ring_ptr.sv
// Ring pointer: restarts at first_idx, and on advance steps by one or
// returns to first_idx when the wrap flag is set or last_idx is reached.
// Assumes the caller asserts advance only for a valid descriptor.
module desc_ring_ptr #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             advance,
    input  logic             wrap_flag,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] ptr_q;

    // Pointer register: restart beats advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ptr_q <= '0;
        else if (restart)                      ptr_q <= first_idx;
        else if (advance && (wrap_flag || ptr_q == last_idx)) ptr_q <= first_idx;
        else if (advance)                      ptr_q <= ptr_q + 1'b1;
    end

    assign ptr = ptr_q;

    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ptr_q == $past(first_idx));
    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && wrap_flag) |=> ptr_q == $past(first_idx));
endmodule

// File: rtl/desc_ring_irq.sv
// Interrupt control: write-one-to-clear source bits with set priority,
// a mask register, and a level output from their conjunction.
module desc_ring_irq #(
    parameter int SRC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_i,
    input  logic [SRC_W-1:0] clr_i,
    input  logic             mask_we,
    input  logic [SRC_W-1:0] mask_wdata,
    output logic [SRC_W-1:0] src_o,
    output logic [SRC_W-1:0] mask_o,
    output logic             irq_o
);
    logic [SRC_W-1:0] src_q;
    logic [SRC_W-1:0] mask_q;

    // Source register: clear requested bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= (src_q & ~clr_i) | set_i;
    end

    // Mask register: loaded by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign src_o  = src_q;
    assign mask_o = mask_q;
    assign irq_o  = |(src_q & mask_q);

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((src_q & $past(set_i)) == $past(set_i)));
    assert_w1c_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((src_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/desc_ring_seq.sv
// Descriptor ring sequencer top: host register decode, count register,
// transmit/receive presentation, completion write-back and interrupt
// events. Assumes TABLE_BASE is a multiple of the table size (8*NUM_DESC)
// and that the table end fits in ADDR_W bits.
module desc_ring_seq
    import desc_ring_pkg::*;
#(
    parameter int NUM_DESC   = 128,
    parameter int ADDR_W     = 12,
    parameter int TABLE_BASE = 'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tx_valid,
    output logic [31:0]       tx_addr,
    output logic [15:0]       tx_len,
    output logic              tx_pad,
    output logic              tx_crc,
    input  logic              tx_done,
    input  logic [8:0]        tx_status,
    output logic              rx_valid,
    output logic [31:0]       rx_addr,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_status,
    output logic              irq
);
    localparam int IDX_W  = $clog2(NUM_DESC);
    localparam int WIDX_W = IDX_W + 1;
    localparam int CNT_W  = $clog2(NUM_DESC + 1);
    localparam logic [ADDR_W:0] TBL_LO = (ADDR_W+1)'(TABLE_BASE);
    localparam logic [ADDR_W:0] TBL_HI = (ADDR_W+1)'(TABLE_BASE + 8 * NUM_DESC);

    logic             in_table, sel_src, sel_mask, sel_cnt;
    logic             count_we;
    logic [CNT_W-1:0] cnt_q, cnt_new;
    logic [WIDX_W-1:0] host_widx;
    logic [31:0]      tbl_word, tx_ctl, tx_buf, rx_ctl, rx_buf;
    logic [IDX_W-1:0] tx_ptr, rx_ptr, rx_first, tx_last;
    logic             tx_active, rx_active, tx_fire, rx_fire, rx_busy;
    logic             tx_err, rx_err;
    logic [31:0]      tx_wb_word, rx_wb_word;
    logic [SRC_W-1:0] src_set, src_clr, src, mask;

    // Host address decode.
    always_comb begin
        in_table  = ({1'b0, host_addr} >= TBL_LO) && ({1'b0, host_addr} < TBL_HI);
        sel_src   = host_addr == ADDR_W'(OFS_SRC);
        sel_mask  = host_addr == ADDR_W'(OFS_MASK);
        sel_cnt   = host_addr == ADDR_W'(OFS_COUNT);
        host_widx = host_addr[WIDX_W+1:2];
    end

    assign count_we = host_we && sel_cnt;
    assign cnt_new  = (host_wdata > 32'(NUM_DESC)) ? CNT_W'(NUM_DESC)
                                                   : host_wdata[CNT_W-1:0];

    // Count register: clamped transmit descriptor count.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (count_we) cnt_q <= cnt_new;
    end

    // Ring regions derived from the count.
    always_comb begin
        tx_active = cnt_q != '0;
        rx_active = cnt_q < CNT_W'(NUM_DESC);
        tx_last   = IDX_W'(cnt_q - 1'b1);
        rx_first  = count_we ? IDX_W'(cnt_new) : IDX_W'(cnt_q);
    end

    desc_ring_table #(.NUM_DESC(NUM_DESC)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we && in_table),
        .host_widx  (host_widx),
        .host_wdata (host_wdata),
        .host_word  (tbl_word),
        .tx_wb      (tx_fire),
        .tx_idx     (tx_ptr),
        .tx_wb_word (tx_wb_word),
        .tx_ctl     (tx_ctl),
        .tx_buf     (tx_buf),
        .rx_wb      (rx_fire),
        .rx_idx     (rx_ptr),
        .rx_wb_word (rx_wb_word),
        .rx_ctl     (rx_ctl),
        .rx_buf     (rx_buf)
    );

    desc_ring_ptr #(.IDX_W(IDX_W)) u_tx_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (count_we),
        .first_idx ('0),
        .last_idx  (tx_last),
        .advance   (tx_fire),
        .wrap_flag (tx_ctl[BIT_WRAP]),
        .ptr       (tx_ptr)
    );

    desc_ring_ptr #(.IDX_W(IDX_W)) u_rx_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (count_we),
        .first_idx (rx_first),
        .last_idx  (IDX_W'(NUM_DESC - 1)),
        .advance   (rx_fire),
        .wrap_flag (rx_ctl[BIT_WRAP]),
        .ptr       (rx_ptr)
    );

    // Presentation to the frame engines.
    always_comb begin
        tx_valid = tx_active && tx_ctl[BIT_OWN];
        tx_addr  = tx_buf;
        tx_len   = tx_ctl[LEN_LSB +: 16];
        tx_pad   = tx_ctl[BIT_PAD];
        tx_crc   = tx_ctl[BIT_CRC];
        rx_valid = rx_active && rx_ctl[BIT_OWN];
        rx_addr  = rx_buf;
    end

    // Completion handling and write-back words.
    always_comb begin
        tx_fire    = tx_done && tx_valid;
        rx_fire    = rx_done && rx_valid;
        rx_busy    = rx_done && !rx_valid;
        tx_err     = (tx_status & TX_ERR_MASK) != '0;
        rx_err     = (rx_status & RX_ERR_MASK) != '0;
        tx_wb_word = (tx_ctl & TX_KEEP) | 32'(tx_status);
        rx_wb_word = (rx_ctl & RX_KEEP) | {rx_len, 7'b0, rx_status};
    end

    // Interrupt events and host clear.
    always_comb begin
        src_set             = '0;
        src_set[SRC_TX_OK]  = tx_fire && tx_ctl[BIT_IRQ] && !tx_err;
        src_set[SRC_TX_ERR] = tx_fire && tx_ctl[BIT_IRQ] && tx_err;
        src_set[SRC_RX_OK]  = rx_fire && rx_ctl[BIT_IRQ] && !rx_err;
        src_set[SRC_RX_ERR] = rx_fire && rx_ctl[BIT_IRQ] && rx_err;
        src_set[SRC_BUSY]   = rx_busy;
        src_clr             = (host_we && sel_src) ? host_wdata[SRC_W-1:0] : '0;
    end

    desc_ring_irq #(.SRC_W(SRC_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (src_set),
        .clr_i      (src_clr),
        .mask_we    (host_we && sel_mask),
        .mask_wdata (host_wdata[SRC_W-1:0]),
        .src_o      (src),
        .mask_o     (mask),
        .irq_o      (irq)
    );

    // Host read-back mux.
    always_comb begin
        host_rdata = '0;
        if (in_table)      host_rdata = tbl_word;
        else if (sel_src)  host_rdata = 32'(src);
        else if (sel_mask) host_rdata = 32'(mask);
        else if (sel_cnt)  host_rdata = 32'(cnt_q);
    end

    assert_tx_in_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (CNT_W'(tx_ptr) < cnt_q));
    assert_rx_in_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (CNT_W'(rx_ptr) >= cnt_q));
    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !count_we) |=> $stable(tx_ptr));
    assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !count_we) |=> $stable(rx_ptr));
endmodule

// File: tb/desc_ring_seq_bench.sv
module desc_ring_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 8;
    localparam int AW = 12;

    logic clk = 0, rst_n = 0;
    logic host_we = 0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic tx_valid, tx_pad, tx_crc, rx_valid, irq;
    logic [31:0] tx_addr, rx_addr;
    logic [15:0] tx_len;
    logic tx_done = 0, rx_done = 0;
    logic [8:0] tx_status = '0, rx_status = '0;
    logic [15:0] rx_len = '0;

    desc_ring_seq #(.NUM_DESC(ND), .ADDR_W(AW), .TABLE_BASE('h400)) u_desc_ring_seq (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_addr(tx_addr), .tx_len(tx_len), .tx_pad(tx_pad),
        .tx_crc(tx_crc), .tx_done(tx_done), .tx_status(tx_status),
        .rx_valid(rx_valid), .rx_addr(rx_addr), .rx_done(rx_done), .rx_len(rx_len),
        .rx_status(rx_status), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    logic [31:0] m_mem [2*ND];
    int m_n = 0, m_txp = 0, m_rxp = 0;
    logic [4:0] m_src = '0, m_mask = '0;
    int checks = 0, errors = 0;
    bit done_flag = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [AW-1:0] a);
        if (a >= 'h400 && a < 'h400 + 8*ND) return m_mem[(a - 'h400) >> 2];
        if (a == 'h04) return 32'(m_src);
        if (a == 'h08) return 32'(m_mask);
        if (a == 'h20) return 32'(m_n);
        return 32'h0;
    endfunction

    task automatic model_step();
        logic [31:0] w, txword, rxword;
        logic [4:0] set, clr;
        int ntx, nrx, txi, rxi;
        bit txw, rxw;
        if (!rst_n) begin
            for (int i = 0; i < 2*ND; i++) m_mem[i] = '0;
            m_n = 0; m_txp = 0; m_rxp = 0; m_src = '0; m_mask = '0;
            return;
        end
        set = '0; clr = '0; ntx = m_txp; nrx = m_rxp; txw = 0; rxw = 0;
        txi = 0; rxi = 0; txword = '0; rxword = '0;
        if (tx_done && m_n > 0 && m_mem[2*m_txp][15]) begin
            w = m_mem[2*m_txp]; txw = 1; txi = 2*m_txp;
            txword = {w[31:16], 1'b0, w[14:9], tx_status};
            if (w[14]) begin
                if ((tx_status & 9'h10F) != 0) set[1] = 1; else set[0] = 1;
            end
            ntx = (w[13] || m_txp == m_n - 1) ? 0 : m_txp + 1;
        end
        if (rx_done) begin
            if (m_n < ND && m_mem[2*m_rxp][15]) begin
                w = m_mem[2*m_rxp]; rxw = 1; rxi = 2*m_rxp;
                rxword = {rx_len, 1'b0, w[14:9], rx_status};
                if (w[14]) begin
                    if ((rx_status & 9'h0FF) != 0) set[3] = 1; else set[2] = 1;
                end
                nrx = (w[13] || m_rxp == ND - 1) ? m_n : m_rxp + 1;
            end else set[4] = 1;
        end
        if (host_we) begin
            if (host_addr >= 'h400 && host_addr < 'h400 + 8*ND)
                m_mem[(host_addr - 'h400) >> 2] = host_wdata;
            else if (host_addr == 'h04) clr = host_wdata[4:0];
            else if (host_addr == 'h08) m_mask = host_wdata[4:0];
            else if (host_addr == 'h20) begin
                m_n = (host_wdata > ND) ? ND : int'(host_wdata);
                ntx = 0; nrx = m_n;
            end
        end
        if (txw) m_mem[txi] = txword;
        if (rxw) m_mem[rxi] = rxword;
        m_src = (m_src & ~clr) | set;
        m_txp = ntx; m_rxp = nrx;
    endtask

    task automatic compare_all();
        logic [31:0] w;
        bit etv, erv;
        etv = 0; erv = 0;
        if (m_n > 0) etv = m_mem[2*m_txp][15];
        if (m_n < ND) erv = m_mem[2*m_rxp][15];
        chk("R4 tx_valid", 32'(tx_valid), 32'(etv));
        if (etv) begin
            w = m_mem[2*m_txp];
            chk("R4 tx_addr", tx_addr, m_mem[2*m_txp+1]);
            chk("R4 tx_len", 32'(tx_len), 32'(w[31:16]));
            chk("R4 tx_pad_crc", {30'b0, tx_pad, tx_crc}, {30'b0, w[12], w[11]});
        end
        chk("R6 rx_valid", 32'(rx_valid), 32'(erv));
        if (erv) chk("R6 rx_addr", rx_addr, m_mem[2*m_rxp+1]);
        chk("R12 irq", 32'(irq), 32'(|(m_src & m_mask)));
        chk("R2 host_rdata", host_rdata, m_read(host_addr));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (rst_n) compare_all();
    endtask

    task automatic hw(input logic [AW-1:0] a, input logic [31:0] d);
        host_we = 1; host_addr = a; host_wdata = d;
        cycle();
        host_we = 0;
    endtask

    task automatic txd(input logic [8:0] st);
        tx_done = 1; tx_status = st;
        cycle();
        tx_done = 0;
    endtask

    task automatic rxd(input logic [15:0] len, input logic [8:0] st);
        rx_done = 1; rx_len = len; rx_status = st;
        cycle();
        rx_done = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        host_addr = a;
        #1;
        chk(req, host_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2*ND; i++) m_mem[i] = '0;
        rst_n = 0;
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        // R1: reset state
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_valid", 32'(rx_valid), 0);
        chk("R1 irq", 32'(irq), 0);
        rd('h20, 0, "R1 count");
        rd('h404, 0, "R1 table");

        // transmit ring: count 3
        hw('h08, 32'h1F);
        hw('h400, 32'h003C_D000); hw('h404, 32'h1000);
        hw('h408, 32'h0064_8800); hw('h40C, 32'h2000);
        hw('h414, 32'h3000);
        hw('h20, 3);
        chk("R4 tx_valid lit", 32'(tx_valid), 1);
        chk("R4 tx_addr lit", tx_addr, 32'h1000);
        chk("R4 tx_len lit", 32'(tx_len), 60);
        txd(9'h000);
        rd('h04, 32'h01, "R10 tx ok source");
        rd('h400, 32'h003C_5000, "R5 status write-back");
        txd(9'h004);
        rd('h04, 32'h01, "R10 no irq enable");
        rd('h408, 32'h0064_0804, "R5 late collision write-back");
        chk("R9 tx stopped", 32'(tx_valid), 0);
        txd(9'h000);
        rd('h410, 32'h0, "R9 done ignored");
        hw('h410, 32'h0020_E000);
        chk("R4 desc2 addr", tx_addr, 32'h3000);
        txd(9'h008);
        rd('h04, 32'h03, "R10 tx error source");
        hw('h400, 32'h003C_8000);
        chk("R8 tx wrap to 0", tx_addr, 32'h1000);
        hw('h04, 32'h03);
        chk("R12 cleared irq", 32'(irq), 0);

        // receive ring: indices 3..7
        hw('h41C, 32'h8000); hw('h418, 32'h0000_C000);
        hw('h424, 32'h8800); hw('h420, 32'h0000_E000);
        chk("R6 rx_addr lit", rx_addr, 32'h8000);
        rxd(16'd64, 9'h000);
        rd('h418, 32'h0040_4000, "R7 rx write-back");
        rd('h04, 32'h04, "R10 rx ok source");
        rxd(16'd70, 9'h002);
        rd('h04, 32'h0C, "R10 rx error source");
        rd('h420, 32'h0046_6002, "R7 rx error write-back");
        chk("R8 rx wrap to first", 32'(rx_valid), 0);
        rxd(16'd10, 9'h000);
        rd('h04, 32'h1C, "R11 busy source");
        rd('h418, 32'h0040_4000, "R11 table unchanged");

        // end-of-region wrap with count 6
        hw('h434, 32'h9000); hw('h430, 32'h0000_C000);
        hw('h43C, 32'h9800); hw('h438, 32'h0000_8000);
        hw('h20, 6);
        chk("R3 rx restart", rx_addr, 32'h9000);
        rxd(16'd1, 9'h000);
        chk("R6 rx next", rx_addr, 32'h9800);
        rxd(16'd2, 9'h000);
        hw('h430, 32'h0000_C000);
        chk("R8 rx end-of-region wrap", rx_addr, 32'h9000);

        // clamp and set-over-clear
        hw('h20, 200);
        rd('h20, 8, "R3 count clamp");
        chk("R6 no rx ring", 32'(rx_valid), 0);
        host_we = 1; host_addr = 'h04; host_wdata = 32'h1F; rx_done = 1;
        cycle();
        host_we = 0; rx_done = 0;
        rd('h04, 32'h10, "R12 set wins over clear");
        hw('h08, 32'h0F);
        chk("R12 masked", 32'(irq), 0);

        // restart with count 3
        hw('h20, 3);
        chk("R3 tx restart", tx_addr, 32'h1000);
        hw('h418, 32'h0000_C000);
        chk("R3 rx first", rx_addr, 32'h8000);

        // engine beats host on same word
        host_we = 1; host_addr = 'h400; host_wdata = 32'hFFFF_FFFF;
        tx_done = 1; tx_status = 9'h000;
        cycle();
        host_we = 0; tx_done = 0;
        rd('h400, 32'h003C_0000, "R5 engine precedence");

        repeat (2) cycle();
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule